// File: doc/BRIEF.md
# Event Snapshot Counter

A free-running binary count is frozen into a capture register when an asynchronous external event line goes from low to high. The time between events, measured in clock cycles, is the raw material for entropy collection. After a capture the block disarms itself, so later edges cannot overwrite a value the host has not yet read.

The block re-arms in one of two ways. In host mode it waits for a done acknowledge from the host. In timed mode it re-arms by itself once a programmed hold-off has run out. In both modes a re-arm only counts a fresh low-to-high transition of the event line. If the line is already high at re-arm, that level is ignored.

The host reads the 24-bit snapshot through one 8-bit bus in three byte lanes, each with its own enable. A capture raises a valid flag and sends a one-cycle interrupt pulse.

Top module: `evt_snap_ctr`

## Requirements
- R1: The counter is 24 bits wide and advances by one on every clock, wrapping from 0xFFFFFF to 0. All 24 bits are stored into the snapshot on the same clock.
- R2: When `clr_i` is high at a clock edge, the counter holds 0 after that edge. It counts up again from the next edge on.
- R3: `evt_i` passes through two synchronizing flops. A low-to-high change first sampled at edge k is captured at edge k+2. The snapshot then holds the count present just before edge k+2. If `clr_i` and a rising `evt_i` are applied in the same cycle, the snapshot reads 1.
- R4: The snapshot does not change while the event line stays high, however long it stays high.
- R5: In host mode (`lock_mode_i`=0) the block is disarmed after a capture. Every event edge is dropped until `done_i` has been sampled high. An edge that is detected in the same cycle as `done_i` is also dropped.
- R6: If the event line is already high when the block re-arms, it causes no capture. The next low-to-high transition is captured.
- R7: A capture sets `cap_valid_o` and drives `irq_o` high for exactly one cycle. `done_i` clears `cap_valid_o` in either mode.
- R8: Lane enable bit i puts snapshot bits [8i+7:8i] on `rd_bus_o`. When several bits are set, the lowest-numbered lane wins. With no bit set, the bus is all high-impedance.
- R9: In timed mode (`lock_mode_i`=1) with a hold-off value N, the block re-arms N+1 cycles after a capture. An edge detected in the cycle after re-arm is captured, so the earliest next capture comes N+2 edges after the previous one. `done_i` does not re-arm the block in this mode.
- R10: In timed mode a hold-off value of 0 re-arms the block on the cycle right after a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; after reset the block is armed |
| clr_i | input | 1 | Clears the counter to zero |
| evt_i | input | 1 | Asynchronous external event line |
| done_i | input | 1 | Host acknowledge: clears the valid flag and re-arms in host mode |
| lock_mode_i | input | 1 | 0 = re-arm by host, 1 = re-arm after the hold-off |
| lock_cycles_i | input | 16 | Hold-off length in cycles for timed mode |
| lane_en_i | input | 3 | Byte lane enables for the read bus |
| rd_bus_o | output | 8 | Shared snapshot read bus |
| cap_valid_o | output | 1 | A snapshot is held and not yet acknowledged |
| irq_o | output | 1 | One-cycle pulse on each capture |

## Verification
A wrong arm state shows up at the ports at once. Either the interrupt fires for an edge that should have been dropped, or a legal edge produces no pulse on the third clock after it reaches the input. A stale or torn snapshot shows on the read bus as soon as a lane is enabled. Because the bench sweeps the lane enables every cycle, a corrupted byte is seen within a few cycles. A counter that skips or stalls moves every later snapshot away from the value expected from the cycle count, so the first capture after the fault exposes it.

// File: rtl/evt_snap_pkg.sv
package evt_snap_pkg;
    // Re-arm source after a capture
    typedef enum logic {
        REARM_HOST  = 1'b0,
        REARM_TIMED = 1'b1
    } rearm_mode_e;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/evt_free_ctr.sv
module evt_free_ctr #(
    parameter int WIDTH = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    output logic [WIDTH-1:0] cnt_o
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr_i ? '0 : cnt_q + WIDTH'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_arm_ctrl.sv
module evt_arm_ctrl
    import evt_snap_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int LOCK_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rise_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              done_i,
    input  rearm_mode_e       mode_i,
    input  logic [LOCK_W-1:0] hold_i,
    output logic [CNT_W-1:0]  snap_o,
    output logic              valid_o,
    output logic              irq_o
);
    typedef struct packed {
        logic              armed;
        logic              valid;
        logic              irq;
        logic [LOCK_W-1:0] hold;
        logic [CNT_W-1:0]  snap;
    } arm_state_t;

    arm_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (done_i) begin
            st_d.valid = 1'b0;
            if (mode_i == REARM_HOST) st_d.armed = 1'b1;
        end
        // timed hold-off runs down while disarmed
        if (!st_q.armed && mode_i == REARM_TIMED) begin
            if (st_q.hold == '0) st_d.armed = 1'b1;
            else                 st_d.hold  = st_q.hold - LOCK_W'(1);
        end
        // capture overrides any same-cycle re-arm
        if (st_q.armed && rise_i) begin
            st_d.snap  = cnt_i;
            st_d.armed = 1'b0;
            st_d.valid = 1'b1;
            st_d.irq   = 1'b1;
            st_d.hold  = hold_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{armed: 1'b1, valid: 1'b0, irq: 1'b0, hold: '0, snap: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o  = st_q.snap;
    assign valid_o = st_q.valid;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/evt_lane_mux.sv
module evt_lane_mux #(
    parameter int LANE_W = 8,
    parameter int LANES  = 3,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [LANES-1:0]  en_i,
    output logic [LANE_W-1:0] bus_o
);
    logic [LANE_W-1:0] lane_data [LANES];
    logic [LANE_W-1:0] pick;
    logic              hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_data[g] = data_i[g*LANE_W +: LANE_W];
    end

    // walk downward so the lowest enabled lane is the last written
    always_comb begin
        pick = '0;
        hit  = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (en_i[i]) begin
                pick = lane_data[i];
                hit  = 1'b1;
            end
        end
    end

    assign bus_o = hit ? pick : {LANE_W{1'bz}};
endmodule

// File: rtl/evt_snap_ctr.sv
module evt_snap_ctr
    import evt_snap_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int LANE_W      = 8,
    parameter int LOCK_W      = 16,
    parameter int SYNC_STAGES = 2,
    localparam int LANES      = CNT_W / LANE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              evt_i,
    input  logic              done_i,
    input  logic              lock_mode_i,
    input  logic [LOCK_W-1:0] lock_cycles_i,
    input  logic [LANES-1:0]  lane_en_i,
    output logic [LANE_W-1:0] rd_bus_o,
    output logic              cap_valid_o,
    output logic              irq_o
);
    logic             evt_rise;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;

    evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (evt_i),
        .rise_o  (evt_rise)
    );

    evt_free_ctr #(.WIDTH(CNT_W)) u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .cnt_o  (cnt_q)
    );

    evt_arm_ctrl #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) u_arm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rise_i  (evt_rise),
        .cnt_i   (cnt_q),
        .done_i  (done_i),
        .mode_i  (rearm_mode_e'(lock_mode_i)),
        .hold_i  (lock_cycles_i),
        .snap_o  (snap_q),
        .valid_o (cap_valid_o),
        .irq_o   (irq_o)
    );

    evt_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
        .data_i (snap_q),
        .en_i   (lane_en_i),
        .bus_o  (rd_bus_o)
    );
endmodule

// File: rtl/evt_snap_ctr_chk.sv
module evt_snap_ctr_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clr_i,
    input logic             done_i,
    input logic             lock_mode_i,
    input logic             irq_o,
    input logic             cap_valid_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] snap_q
);
    assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> cnt_q == '0);

    assert_snap_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> $stable(snap_q));

    assert_no_capture_disarmed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lock_mode_i && cap_valid_o && !done_i) |=> !irq_o);

    assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    assert_irq_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> cap_valid_o);
endmodule

bind evt_snap_ctr evt_snap_ctr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .done_i      (done_i),
    .lock_mode_i (lock_mode_i),
    .irq_o       (irq_o),
    .cap_valid_o (cap_valid_o),
    .cnt_q       (cnt_q),
    .snap_q      (snap_q)
);

// File: tb/evt_snap_ctr_tb_top.sv
module evt_snap_ctr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        evt = 1'b0;
    logic        done = 1'b0;
    logic        lmode = 1'b0;
    logic [15:0] lcyc = 16'd0;
    logic [2:0]  len = 3'b000;
    wire  [7:0]  rd_bus;
    wire         valid;
    wire         irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    evt_snap_ctr dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .clr_i         (clr),
        .evt_i         (evt),
        .done_i        (done),
        .lock_mode_i   (lmode),
        .lock_cycles_i (lcyc),
        .lane_en_i     (len),
        .rd_bus_o      (rd_bus),
        .cap_valid_o   (valid),
        .irq_o         (irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every clock
    int m_hist[$];
    int unsigned m_cnt, m_snap;
    bit m_armed, m_valid, m_irq;
    int m_hold;
    int irq_seen;

    function automatic int exp_lane(input int unsigned snap, input logic [2:0] en);
        for (int i = 0; i < 3; i++) if (en[i]) return (snap >> (8 * i)) & 8'hFF;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = '{0, 0, 0};
            m_cnt = 0; m_snap = 0; m_armed = 1; m_valid = 0; m_irq = 0; m_hold = 0;
        end else begin
            bit rise;
            bit arm_n, val_n, irq_n;
            int unsigned snap_n;
            int hold_n;
            rise   = (m_hist[1] == 1) && (m_hist[2] == 0);
            arm_n  = m_armed; val_n = m_valid; irq_n = 0; snap_n = m_snap; hold_n = m_hold;
            if (done) begin val_n = 0; if (!lmode) arm_n = 1; end
            if (!m_armed && lmode) begin
                if (m_hold == 0) arm_n = 1; else hold_n = m_hold - 1;
            end
            if (m_armed && rise) begin
                snap_n = m_cnt; arm_n = 0; val_n = 1; irq_n = 1; hold_n = lcyc;
            end
            m_hist.push_front(int'(evt));
            void'(m_hist.pop_back());
            m_cnt   = clr ? 0 : ((m_cnt + 1) & 32'hFFFFFF);
            m_armed = arm_n; m_valid = val_n; m_irq = irq_n; m_snap = snap_n; m_hold = hold_n;
            #2;
            chk(irq === m_irq, "R7 irq", irq, m_irq);
            chk(valid === m_valid, "R7 valid", valid, m_valid);
            if (len != 3'b000)
                chk(int'(rd_bus) == exp_lane(m_snap, len), "R8/R3 bus", rd_bus, exp_lane(m_snap, len));
            if (irq) irq_seen++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done();
        done = 1'b1; tick(1); done = 1'b0;
    endtask

    task automatic read_snap(output int unsigned v);
        v = 0;
        for (int i = 0; i < 3; i++) begin
            len = 3'(1 << i); #1;
            v = v | (int'(rd_bus) << (8 * i));
        end
        len = 3'b000;
    endtask

    initial begin
        int unsigned v;
        int base;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // reset state
        chk(valid === 1'b0, "R7 reset valid", valid, 0);
        chk(irq === 1'b0, "R7 reset irq", irq, 0);
        read_snap(v);
        chk(v == 0, "R8 reset snapshot", v, 0);

        // R2 R3: clear and event in the same cycle gives snapshot 1
        clr = 1'b1; evt = 1'b1; tick(1); clr = 1'b0;
        tick(3);
        read_snap(v);
        chk(v == 1, "R3 snapshot after clear", v, 1);
        chk(valid === 1'b1, "R7 valid after capture", valid, 1);
        // R4: long high level does not move the snapshot
        tick(40);
        read_snap(v);
        chk(v == 1, "R4 snapshot held", v, 1);

        // R5: edges while disarmed are dropped
        base = irq_seen;
        evt = 1'b0; tick(3); evt = 1'b1; tick(3); evt = 1'b0; tick(3); evt = 1'b1; tick(4);
        chk(irq_seen == base, "R5 no capture while disarmed", irq_seen, base);
        read_snap(v);
        chk(v == 1, "R5 snapshot untouched", v, 1);

        // R6: event still high at re-arm is ignored
        pulse_done();
        tick(10);
        chk(irq_seen == base, "R6 held level ignored", irq_seen, base);
        chk(valid === 1'b0, "R7 valid cleared by done", valid, 0);
        evt = 1'b0; tick(3); evt = 1'b1; tick(5);
        chk(irq_seen == base + 1, "R6 next rise captured", irq_seen, base + 1);

        // R1 R8: long run so upper lanes carry data; sweep lane enables
        pulse_done(); evt = 1'b0;
        for (int k = 0; k < 70000; k++) begin
            len = 3'(k % 8);
            if (k == 69990) evt = 1'b1;
            tick(1);
        end
        len = 3'b000;
        tick(4);
        read_snap(v);
        chk(v > 32'h10000, "R1 wide snapshot", v, 32'h10000);
        len = 3'b110; #1;
        chk(int'(rd_bus) == ((v >> 8) & 8'hFF), "R8 lowest lane wins", rd_bus, (v >> 8) & 8'hFF);
        len = 3'b000;

        // R9: timed mode, hold-off 5, done has no re-arm effect
        evt = 1'b0; lmode = 1'b1; lcyc = 16'd5; pulse_done();
        tick(5);
        base = irq_seen;
        for (int k = 0; k < 60; k++) begin
            evt = k[0];
            done = (k % 7 == 0);
            tick(1);
        end
        done = 1'b0; evt = 1'b0;
        tick(4);
        chk(irq_seen > base, "R9 automatic re-arm", irq_seen - base, 1);
        chk(irq_seen - base <= 9, "R9 hold-off spacing", irq_seen - base, 9);

        // R10: hold-off zero
        lcyc = 16'd0; tick(10);
        base = irq_seen;
        for (int k = 0; k < 40; k++) begin
            evt = k[1];
            tick(1);
        end
        evt = 1'b0; tick(4);
        chk(irq_seen - base == 10, "R10 zero hold-off", irq_seen - base, 10);

        finished = 1'b1;
        tick(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule